// File: doc/BRIEF.md
# Interrupt-Acknowledge Chip-Select Channel

This block is one programmable chip-select channel for a 68k-style asynchronous bus. It watches every bus cycle and drives an active-low select for cycles that fall in its programmed address block and meet its option qualifiers. It can also be set up to answer interrupt-acknowledge cycles. These are processor-space cycles whose upper address bits are all ones and which carry the acknowledged level on address bits [3:1]. For such cycles the channel can end the cycle with an autovector termination instead of a data-size acknowledge. It then inserts a programmable number of wait states before the termination.

Software writes two 16-bit registers through a single write port. `reg_sel_i` = 0 selects the base register. Its bits [15:3] are compared with address bits [23:11], so a base value of 16'hFFF8 or higher reaches the acknowledge range.

`reg_sel_i` = 1 selects the option register, with these fields:

| Field | Bits |
|-------|------|
| mode | [15] |
| byte select | [14:13] |
| read/write select | [12:11] |
| strobe | [10] |
| wait count | [9:6] |
| space | [5:4] |
| level | [3:1] |
| autovector | [0] |

Top module: `iack_cs`

## Requirements
- R1: After reset both registers are zero, all three outputs are high, and no cycle produces a select until a nonzero byte-select field has been programmed.
- R2: A cycle is selected only when address bits [23:11] equal base register bits [15:3].
- R3: Space field: 00 matches only function code 3'b111 (processor space). 01 matches function codes with bit 2 clear. 10 matches function codes with bit 2 set, other than 3'b111. 11 matches any function code other than 3'b111.
- R4: In processor space with a nonzero level field, the cycle matches only when address bits [3:1] equal the level field. A zero level field matches levels 1 to 7 and rejects level 0.
- R5: Byte-select bit 1 qualifies the upper-byte enable and bit 0 qualifies the lower-byte enable. The cycle matches if any enabled byte lane is active.
- R6: Read/write-select bit 0 allows reads (rw_i=1) and bit 1 allows writes (rw_i=0).
- R7: With strobe = 0, cs_no goes low one clock after the first edge that samples as_ni low. With strobe = 1, cs_no also requires ds_ni to be sampled low.
- R8: For a matched cycle with wait count N, the termination output goes low N+1 clocks after the select, and stays low until the strobe negates.
- R9: When the autovector bit is 1 and the space field is 00, the termination is avec_no and dsack_no stays high. Otherwise the termination is dsack_no and avec_no stays high. avec_no and dsack_no are never low together.
- R10: With mode = 1, the select asserts but neither termination output asserts.
- R11: All outputs are high one clock after as_ni is sampled high. Each new assertion of as_ni restarts the wait count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = base register, 1 = option register |
| reg_wdata_i | input | 16 | Register write data |
| addr_i | input | 24 | Bus address |
| fc_i | input | 3 | Function code (address space) |
| rw_i | input | 1 | 1 = read, 0 = write |
| ube_i | input | 1 | Upper byte enable |
| lbe_i | input | 1 | Lower byte enable |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| cs_no | output | 1 | Chip select, active low |
| avec_no | output | 1 | Autovector termination, active low |
| dsack_no | output | 1 | Data-size acknowledge, active low |

## Verification
The assertions assume that as_ni is already synchronous to the clock. They also assume that every negation of the strobe lasts for at least one sampling edge, so that each bus cycle is seen as a separate start. The bench changes all bus inputs and register writes only at falling clock edges. It holds the address, function code and lanes steady for the whole strobe, and it always returns as_ni high for at least one full clock between cycles. Register writes are made only while the strobe is negated.

// File: rtl/iack_cs_pkg.sv
package iack_cs_pkg;
  localparam int WS_W = 4;

  typedef enum logic [1:0] {
    SP_CPU  = 2'b00,
    SP_USER = 2'b01,
    SP_SUPV = 2'b10,
    SP_ANY  = 2'b11
  } space_e;

  typedef struct packed {
    logic            mode;
    logic [1:0]      byte_sel;
    logic [1:0]      rw_sel;
    logic            strb;
    logic [WS_W-1:0] wait_n;
    space_e          space;
    logic [2:0]      ipl;
    logic            avec;
  } opt_t;

  localparam logic [2:0] FC_CPU = 3'b111;
endpackage

// File: rtl/iack_cs_regs.sv
module iack_cs_regs
  import iack_cs_pkg::*;
#(
  parameter int CMP_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [CMP_W-1:0] base_o,
  output opt_t             opt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      opt_o  <= '0;
    end else if (reg_we_i) begin
      if (reg_sel_i) opt_o  <= opt_t'(reg_wdata_i);
      else           base_o <= reg_wdata_i[15 -: CMP_W];
    end
  end
endmodule

// File: rtl/iack_cs_match.sv
module iack_cs_match
  import iack_cs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CMP_LSB = 11,
  localparam int CMP_W  = ADDR_W - CMP_LSB
) (
  input  logic [CMP_W-1:0]  base_i,
  input  opt_t              opt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic              ube_i,
  input  logic              lbe_i,
  output logic              hit_o,
  output logic              cpu_o
);
  logic [2:0] level;
  logic addr_hit, space_hit, ipl_hit, byte_hit, rw_hit;
  logic unused_addr;

  assign level       = addr_i[3:1];
  assign unused_addr = ^{addr_i[CMP_LSB-1:4], addr_i[0]};
  assign addr_hit    = addr_i[ADDR_W-1:CMP_LSB] == base_i;
  assign cpu_o       = opt_i.space == SP_CPU;

  always_comb begin
    unique case (opt_i.space)
      SP_CPU:  space_hit = fc_i == FC_CPU;
      SP_USER: space_hit = !fc_i[2];
      SP_SUPV: space_hit = fc_i[2] && fc_i != FC_CPU;
      default: space_hit = fc_i != FC_CPU;
    endcase
  end

  // level check only applies to acknowledge (processor-space) matches
  assign ipl_hit  = !cpu_o ||
                    ((opt_i.ipl == 3'd0) ? (level != 3'd0) : (opt_i.ipl == level));
  assign byte_hit = (opt_i.byte_sel[1] & ube_i) | (opt_i.byte_sel[0] & lbe_i);
  assign rw_hit   = (opt_i.rw_sel[0] & rw_i) | (opt_i.rw_sel[1] & ~rw_i);
  assign hit_o    = addr_hit & space_hit & ipl_hit & byte_hit & rw_hit;
endmodule

// File: rtl/iack_cs_timer.sv
module iack_cs_timer
  import iack_cs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            as_ni,
  input  logic            ds_ni,
  input  logic            hit_i,
  input  logic            avec_en_i,
  input  logic            strb_i,
  input  logic            mode_i,
  input  logic [WS_W-1:0] wait_i,
  output logic            active_o,
  output logic            cs_no,
  output logic            avec_no,
  output logic            dsack_no
);
  logic            as_q, ds_q, term_q, avec_q, strb_q, noterm_q;
  logic [WS_W-1:0] cnt_q, ws_q;
  logic            start;

  assign start = !as_ni && as_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q     <= 1'b1;
      ds_q     <= 1'b0;
      active_o <= 1'b0;
      term_q   <= 1'b0;
      cnt_q    <= '0;
      ws_q     <= '0;
      avec_q   <= 1'b0;
      strb_q   <= 1'b0;
      noterm_q <= 1'b0;
    end else begin
      as_q <= as_ni;
      ds_q <= ~ds_ni;
      if (as_ni) begin
        active_o <= 1'b0;
        term_q   <= 1'b0;
        cnt_q    <= '0;
      end else if (start) begin
        // qualification and timing frozen for the whole cycle
        active_o <= hit_i;
        term_q   <= 1'b0;
        cnt_q    <= '0;
        ws_q     <= wait_i;
        avec_q   <= avec_en_i;
        strb_q   <= strb_i;
        noterm_q <= mode_i;
      end else if (active_o) begin
        if (cnt_q == ws_q) term_q <= ~noterm_q;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign cs_no    = ~(active_o & (~strb_q | ds_q));
  assign avec_no  = ~(term_q & avec_q);
  assign dsack_no = ~(term_q & ~avec_q);
endmodule

// File: rtl/iack_cs.sv
module iack_cs
  import iack_cs_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CMP_LSB = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        fc_i,
  input  logic              rw_i,
  input  logic              ube_i,
  input  logic              lbe_i,
  input  logic              as_ni,
  input  logic              ds_ni,
  output logic              cs_no,
  output logic              avec_no,
  output logic              dsack_no
);
  localparam int CMP_W = ADDR_W - CMP_LSB;

  logic [CMP_W-1:0] base;
  opt_t             opt;
  logic             hit, cpu, active;

  iack_cs_regs #(.CMP_W(CMP_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .base_o(base), .opt_o(opt)
  );

  iack_cs_match #(.ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_match (
    .base_i(base), .opt_i(opt), .addr_i, .fc_i, .rw_i, .ube_i, .lbe_i,
    .hit_o(hit), .cpu_o(cpu)
  );

  iack_cs_timer u_timer (
    .clk_i, .rst_ni, .as_ni, .ds_ni,
    .hit_i(hit), .avec_en_i(opt.avec & cpu), .strb_i(opt.strb),
    .mode_i(opt.mode), .wait_i(opt.wait_n),
    .active_o(active), .cs_no, .avec_no, .dsack_no
  );
endmodule

// File: rtl/iack_cs_chk.sv
module iack_cs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic as_ni,
  input logic active_i,
  input logic cs_no,
  input logic avec_no,
  input logic dsack_no
);
  assert_term_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!avec_no && !dsack_no));

  assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> (cs_no && avec_no && dsack_no));

  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> !$past(as_ni));

  assert_term_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!avec_no || !dsack_no) |-> $past(active_i));
endmodule

bind iack_cs iack_cs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_ni), .active_i(active),
  .cs_no(cs_no), .avec_no(avec_no), .dsack_no(dsack_no)
);

// File: tb/iack_cs_bench.sv
module iack_cs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [23:0] addr_i = '0;
  logic [2:0]  fc_i = '0;
  logic        rw_i = 1'b1, ube_i = 1'b0, lbe_i = 1'b0;
  logic        as_ni = 1'b1, ds_ni = 1'b1;
  logic        cs_no, avec_no, dsack_no;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  iack_cs u_iack_cs (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [15:0] mk_opt(input logic md, input logic [1:0] bs,
      input logic [1:0] rws, input logic st, input logic [3:0] ws,
      input logic [1:0] sp, input logic [2:0] ipl, input logic av);
    return {md, bs, rws, st, ws, sp, ipl, av};
  endfunction

  // one bus cycle; checks select, wait window, termination and release
  task automatic run(input logic [23:0] a, input logic [2:0] fc, input logic rw,
      input logic ub, input logic lb, input logic dsn, input int ws,
      input logic ecs, input logic eav, input logic eds, input string tag);
    @(negedge clk_i);
    addr_i = a; fc_i = fc; rw_i = rw; ube_i = ub; lbe_i = lb; ds_ni = dsn; as_ni = 1'b0;
    @(negedge clk_i);
    chk(cs_no, ~ecs, {tag, " select"});
    for (int i = 0; i <= ws; i++) begin
      chk(avec_no & dsack_no, 1'b1, {tag, " R8 no early termination"});
      @(negedge clk_i);
    end
    chk(avec_no, ~eav, {tag, " R9 avec"});
    chk(dsack_no, ~eds, {tag, " R9 dsack"});
    @(negedge clk_i);
    chk(avec_no, ~eav, {tag, " R8 avec held"});
    chk(dsack_no, ~eds, {tag, " R8 dsack held"});
    as_ni = 1'b1; ds_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no & avec_no & dsack_no, 1'b1, {tag, " R11 release"});
  endtask

  task automatic t_reset;
    chk(cs_no & avec_no & dsack_no, 1'b1, "R1 outputs after reset");
    run(24'hFFFFFA, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R1 unprogrammed");
  endtask

  task automatic t_iack;
    wr(1'b0, 16'hFFF8);
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd2, 2'b00, 3'd5, 1'b1));
    run(24'hFFFFFA, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b1, 1'b1, 1'b0, "R4 R8 R9 level5 avec");
    run(24'hFFFFF6, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b0, "R4 level3 mismatch");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd1, 2'b00, 3'd0, 1'b1));
    run(24'hFFFFF6, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b1, 1'b0, "R4 any level hits 3");
    run(24'hFFFFF0, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R4 any level rejects 0");
    run(24'h7FFFFA, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R2 address mismatch");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd0, 2'b00, 3'd7, 1'b0));
    run(24'hFFFFFE, 3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b1, "R9 R8 dsack ws0");
  endtask

  task automatic t_space;
    wr(1'b0, 16'h1000);
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd1, 2'b01, 3'd0, 1'b1));
    run(24'h100000, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b1, "R3 R9 user hit dsack");
    run(24'h100000, 3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R3 user rejects supv");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd1, 2'b10, 3'd0, 1'b0));
    run(24'h100000, 3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b1, "R3 supv hit");
    run(24'h100000, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R3 supv rejects cpu");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd1, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b1, "R3 any hit");
    run(24'h100000, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b0, "R3 any rejects cpu");
  endtask

  task automatic t_lanes_rw;
    wr(1'b1, mk_opt(1'b0, 2'b01, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R5 lower only rejects upper");
    run(24'h100000, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b1, "R5 lower only hits lower");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b01, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b001, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R6 read only rejects write");
    run(24'h100000, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b1, "R6 read only hits read");
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b10, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b001, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b1, "R6 write only hits write");
  endtask

  task automatic t_strobe_mode;
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b1, 4'd1, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b0, 1'b1, "R7 strobe waits for ds");
    run(24'h100000, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0, 1, 1'b1, 1'b0, 1'b1, "R7 strobe with ds");
    wr(1'b1, mk_opt(1'b1, 2'b11, 2'b11, 1'b0, 4'd1, 2'b11, 3'd0, 1'b0));
    run(24'h100000, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b0, "R10 mode1 no termination");
  endtask

  task automatic t_restart;
    wr(1'b0, 16'hFFF8);
    wr(1'b1, mk_opt(1'b0, 2'b11, 2'b11, 1'b0, 4'd3, 2'b00, 3'd2, 1'b0));
    @(negedge clk_i);
    addr_i = 24'hFFFFF4; fc_i = 3'b111; rw_i = 1'b1; lbe_i = 1'b1; as_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(cs_no, 1'b0, "R11 partial cycle selected");
    as_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no & dsack_no, 1'b1, "R11 aborted cycle released");
    run(24'hFFFFF4, 3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 3, 1'b1, 1'b0, 1'b1, "R11 restart full wait");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_iack();
    t_space();
    t_lanes_rw();
    t_strobe_mode();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule